// File: doc/BRIEF.md
# Ethernet RMON Statistics Counter Bank

This block keeps the receive and transmit statistics of one Ethernet port. Each cycle the receive side and the transmit side may each present one frame event: a valid strobe, the frame length in bytes, and flags that describe the frame. Every event bumps the matching counters in the same clock edge: the frame and byte totals, the multicast, broadcast and pause totals, the error totals, and one bin of a seven-bin frame-size histogram.

Host software reads the counters through a simple word read port. A read returns the value the counter held in the read cycle and clears that counter, so software can add each read value to its own totals. Byte counters are wider than the data word and are read as a low word followed by a high word. The high part is captured at the low read, so the pair always belongs together. A clear-statistics input zeroes every counter at once. Counters hold at their maximum value if software does not read them in time.

Top module: `rmon_stats_bank`

## Requirements
- R1: A read request (`rdEn` high at a rising edge) yields `rdValid` high and the read value on `rdData` after that edge, for exactly one cycle; without a request `rdValid` is low.
- R2: Each receive event adds one to the receive frame counter and `rxLen` to the receive byte counter; it also adds one to the receive multicast, broadcast and pause counters when the matching flag is set.
- R3: A receive event adds one to the FCS-error, jabber, short-frame, symbol-error and oversize counters when `rxFcsBad`, `rxJabber`, `rxShort`, `rxSymErr` and `rxLong` respectively are set.
- R4: Each transmit event adds one to the transmit frame counter and `txLen` to the transmit byte counter, and adds one to the transmit multicast, broadcast, pause and error counters when `txMcast`, `txBcast`, `txPause` and `txErr` are set.
- R5: Each event adds one to exactly one histogram bin of its direction: bin 0 for a length up to 64, bin 1 for 65 to 127, bin 2 for 128 to 255, bin 3 for 256 to 511, bin 4 for 512 to 1023, bin 5 for 1024 to 1518, bin 6 for 1519 and above.
- R6: Address map: 0 receive bytes low word, 1 receive bytes high word, 2 transmit bytes low word, 3 transmit bytes high word; address 8+k reads frame counter k, with k = 0 rx frames, 1 rx multicast, 2 rx broadcast, 3 rx pause, 4 rx FCS error, 5 rx jabber, 6 rx short, 7 rx symbol error, 8 rx oversize, 9 to 15 rx bins 0 to 6, 16 tx frames, 17 tx multicast, 18 tx broadcast, 19 tx pause, 20 tx error, 21 to 27 tx bins 0 to 6. Any other address reads zero and changes no counter. A low word holds the byte counter bits below `CNT_W`; a high word holds the bits above, zero-extended.
- R7: A read of a frame counter or a byte low word clears that counter; a second read with no event in between returns zero.
- R8: When a read and an increment hit the same counter in the same cycle, the read returns the value before the event and the counter is left at 1, or at the frame length for a byte counter.
- R9: A low-word read captures the high part of the same byte counter; the following high-word read returns that captured part, even if frames arrived in between.
- R10: Frame counters stop at all ones and byte counters stop at 2^`BYTE_W`-1 instead of wrapping.
- R11: The oversize counter is `CNT_W`-1 bits wide and stops at 2^(`CNT_W`-1)-1; when it is read, the top bit of `rdData` shows `rxFifoNotEmpty` in the read cycle.
- R12: `clearStats` high at an edge zeroes every counter and captured high part; an event in the same cycle is dropped.
- R13: After reset every counter reads zero and `rdValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clearStats | input | 1 | Zero all counters |
| rxValid | input | 1 | Receive frame event |
| rxLen | input | LEN_W | Receive frame length in bytes |
| rxFcsBad | input | 1 | Receive frame had a bad FCS |
| rxMcast | input | 1 | Receive frame was multicast |
| rxBcast | input | 1 | Receive frame was broadcast |
| rxPause | input | 1 | Receive frame was a pause frame |
| rxShort | input | 1 | Receive frame was too short |
| rxLong | input | 1 | Receive frame was too long |
| rxJabber | input | 1 | Receive frame was a jabber |
| rxSymErr | input | 1 | Receive frame had a symbol error |
| rxFifoNotEmpty | input | 1 | Receive FIFO holds data; shown in oversize reads |
| txValid | input | 1 | Transmit frame event |
| txLen | input | LEN_W | Transmit frame length in bytes |
| txErr | input | 1 | Transmit frame ended in error |
| txMcast | input | 1 | Transmit frame was multicast |
| txBcast | input | 1 | Transmit frame was broadcast |
| txPause | input | 1 | Transmit frame was a pause frame |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read word address |
| rdData | output | CNT_W | Read value |
| rdValid | output | 1 | Read value present |

## Verification
Every counter moves at the rising edge where its event strobe is high, so a read issued in the next cycle already sees it; a read result appears on `rdData` one edge after the request and stays one cycle. The bench drives all inputs at falling edges and samples `rdData` and `rdValid` at the following falling edge, exactly one register after the request. The same-cycle cases (read with increment, clear with event, low read then late frames before the high read) are driven in the one cycle they name, and their effect is read back through later reads through the port.

// File: rtl/rmon_pkg.sv
package rmon_pkg;

  localparam int NUM_CNT    = 28;
  localparam int IDX_W      = 5;
  localparam int NUM_BINS   = 7;
  localparam int FRAME_BASE = 8;

  // Frame counter indices (address = FRAME_BASE + index)
  localparam int IX_RX_FRM   = 0;
  localparam int IX_RX_MC    = 1;
  localparam int IX_RX_BC    = 2;
  localparam int IX_RX_PS    = 3;
  localparam int IX_RX_FCS   = 4;
  localparam int IX_RX_JAB   = 5;
  localparam int IX_RX_SHORT = 6;
  localparam int IX_RX_SYM   = 7;
  localparam int IX_RX_OVER  = 8;
  localparam int IX_RX_HIST  = 9;
  localparam int IX_TX_FRM   = 16;
  localparam int IX_TX_MC    = 17;
  localparam int IX_TX_BC    = 18;
  localparam int IX_TX_PS    = 19;
  localparam int IX_TX_ERR   = 20;
  localparam int IX_TX_HIST  = 21;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_FRAME = 2'd1,
    SEL_BLO   = 2'd2,
    SEL_BHI   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic               clrAll;
    logic [NUM_CNT-1:0] inc;
    logic [1:0]         byteAdd;   // [0] receive, [1] transmit
    logic               rdReq;
    rdSel_e             rdSel;
    logic               rdDir;     // 0 receive, 1 transmit
    logic [IDX_W-1:0]   rdIdx;
  } rmonCtl_t;

  function automatic logic [2:0] sizeBin(input logic [31:0] len);
    if      (len <= 32'd64)   return 3'd0;
    else if (len <= 32'd127)  return 3'd1;
    else if (len <= 32'd255)  return 3'd2;
    else if (len <= 32'd511)  return 3'd3;
    else if (len <= 32'd1023) return 3'd4;
    else if (len <= 32'd1518) return 3'd5;
    else                      return 3'd6;
  endfunction

endpackage

// File: rtl/rmon_ctrl.sv
module rmon_ctrl
  import rmon_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 6
) (
  input  logic              clearStats,
  input  logic              rxValid,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic              rxFcsBad,
  input  logic              rxMcast,
  input  logic              rxBcast,
  input  logic              rxPause,
  input  logic              rxShort,
  input  logic              rxLong,
  input  logic              rxJabber,
  input  logic              rxSymErr,
  input  logic              txValid,
  input  logic [LEN_W-1:0]  txLen,
  input  logic              txErr,
  input  logic              txMcast,
  input  logic              txBcast,
  input  logic              txPause,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output rmonCtl_t          ctl
);

  localparam logic [ADDR_W-1:0] BYTE_END  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] FRM_START = ADDR_W'(FRAME_BASE);
  localparam logic [ADDR_W-1:0] FRM_END   = ADDR_W'(FRAME_BASE + NUM_CNT);

  logic [2:0]        rxBin;
  logic [2:0]        txBin;
  logic [ADDR_W-1:0] frmOffset;

  assign rxBin     = sizeBin(32'(rxLen));
  assign txBin     = sizeBin(32'(txLen));
  assign frmOffset = rdAddr - FRM_START;

  always_comb begin
    ctl        = '0;
    ctl.clrAll = clearStats;
    ctl.rdReq  = rdEn;

    ctl.inc[IX_RX_FRM]   = rxValid;
    ctl.inc[IX_RX_MC]    = rxValid & rxMcast;
    ctl.inc[IX_RX_BC]    = rxValid & rxBcast;
    ctl.inc[IX_RX_PS]    = rxValid & rxPause;
    ctl.inc[IX_RX_FCS]   = rxValid & rxFcsBad;
    ctl.inc[IX_RX_JAB]   = rxValid & rxJabber;
    ctl.inc[IX_RX_SHORT] = rxValid & rxShort;
    ctl.inc[IX_RX_SYM]   = rxValid & rxSymErr;
    ctl.inc[IX_RX_OVER]  = rxValid & rxLong;
    ctl.inc[IX_TX_FRM]   = txValid;
    ctl.inc[IX_TX_MC]    = txValid & txMcast;
    ctl.inc[IX_TX_BC]    = txValid & txBcast;
    ctl.inc[IX_TX_PS]    = txValid & txPause;
    ctl.inc[IX_TX_ERR]   = txValid & txErr;
    for (int b = 0; b < NUM_BINS; b++) begin
      ctl.inc[IX_RX_HIST + b] = rxValid && (rxBin == 3'(b));
      ctl.inc[IX_TX_HIST + b] = txValid && (txBin == 3'(b));
    end
    ctl.byteAdd = {txValid, rxValid};

    if (rdEn) begin
      if (rdAddr < BYTE_END) begin
        ctl.rdSel = rdAddr[0] ? SEL_BHI : SEL_BLO;
        ctl.rdDir = rdAddr[1];
      end else if (rdAddr >= FRM_START && rdAddr < FRM_END) begin
        ctl.rdSel = SEL_FRAME;
        ctl.rdIdx = frmOffset[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/rmon_dp.sv
module rmon_dp
  import rmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 45,
  parameter int LEN_W  = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  rmonCtl_t         ctl,
  input  logic [LEN_W-1:0] rxLen,
  input  logic [LEN_W-1:0] txLen,
  input  logic             rxFifoNotEmpty,
  output logic [CNT_W-1:0] rdData,
  output logic             rdValid
);

  localparam int HI_W = BYTE_W - CNT_W;

  logic [NUM_CNT-1:0][CNT_W-1:0] cntArr;
  logic [1:0][BYTE_W-1:0]        byteArr;
  logic [1:0][HI_W-1:0]          hiArr;
  logic [1:0][LEN_W-1:0]         lens;

  assign lens = {txLen, rxLen};

  // Frame counters: saturating, clear on read, read wins over increment
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_frame
    localparam logic [CNT_W-1:0] LIM =
      (k == IX_RX_OVER) ? ({CNT_W{1'b1}} >> 1) : {CNT_W{1'b1}};
    logic [CNT_W-1:0] val;
    logic             hit;
    assign hit = (ctl.rdSel == SEL_FRAME) && (ctl.rdIdx == IDX_W'(k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           val <= '0;
      else if (ctl.clrAll)                 val <= '0;
      else if (hit)                        val <= CNT_W'(ctl.inc[k]);
      else if (ctl.inc[k] && val != LIM)   val <= val + 1'b1;
    end
    assign cntArr[k] = val;
  end

  // Byte counters: saturating, low read clears and captures high part
  for (genvar d = 0; d < 2; d++) begin : g_byte
    logic [BYTE_W-1:0] val;
    logic [HI_W-1:0]   hold;
    logic [BYTE_W:0]   sum;
    logic              loHit;
    assign sum   = {1'b0, val} + (BYTE_W+1)'(lens[d]);
    assign loHit = (ctl.rdSel == SEL_BLO) && (ctl.rdDir == 1'(d));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        val  <= '0;
        hold <= '0;
      end else if (ctl.clrAll) begin
        val  <= '0;
        hold <= '0;
      end else if (loHit) begin
        hold <= val[BYTE_W-1:CNT_W];
        val  <= ctl.byteAdd[d] ? BYTE_W'(lens[d]) : '0;
      end else if (ctl.byteAdd[d]) begin
        val  <= sum[BYTE_W] ? {BYTE_W{1'b1}} : sum[BYTE_W-1:0];
      end
    end
    assign byteArr[d] = val;
    assign hiArr[d]   = hold;
  end

  // Read register: value held before this edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= ctl.rdReq;
      unique case (ctl.rdSel)
        SEL_FRAME: begin
          if (ctl.rdIdx == IDX_W'(IX_RX_OVER))
            rdData <= {rxFifoNotEmpty, cntArr[ctl.rdIdx][CNT_W-2:0]};
          else
            rdData <= cntArr[ctl.rdIdx];
        end
        SEL_BLO: rdData <= byteArr[ctl.rdDir][CNT_W-1:0];
        SEL_BHI: rdData <= CNT_W'(hiArr[ctl.rdDir]);
        default: rdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/rmon_stats_bank.sv
module rmon_stats_bank
  import rmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 45,
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearStats,
  input  logic              rxValid,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic              rxFcsBad,
  input  logic              rxMcast,
  input  logic              rxBcast,
  input  logic              rxPause,
  input  logic              rxShort,
  input  logic              rxLong,
  input  logic              rxJabber,
  input  logic              rxSymErr,
  input  logic              rxFifoNotEmpty,
  input  logic              txValid,
  input  logic [LEN_W-1:0]  txLen,
  input  logic              txErr,
  input  logic              txMcast,
  input  logic              txBcast,
  input  logic              txPause,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              rdValid
);

  rmonCtl_t ctl;

  rmon_ctrl #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clearStats(clearStats),
    .rxValid(rxValid), .rxLen(rxLen), .rxFcsBad(rxFcsBad),
    .rxMcast(rxMcast), .rxBcast(rxBcast), .rxPause(rxPause),
    .rxShort(rxShort), .rxLong(rxLong), .rxJabber(rxJabber),
    .rxSymErr(rxSymErr),
    .txValid(txValid), .txLen(txLen), .txErr(txErr),
    .txMcast(txMcast), .txBcast(txBcast), .txPause(txPause),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .ctl(ctl)
  );

  rmon_dp #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rxLen(rxLen), .txLen(txLen), .rxFifoNotEmpty(rxFifoNotEmpty),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/rmon_stats_sva.sv
module rmon_stats_sva
  import rmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearStats,
  input logic              rxValid,
  input logic              rxFifoNotEmpty,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [CNT_W-1:0]  rdData,
  input logic              rdValid
);

  localparam logic [ADDR_W-1:0] A_RXFR = ADDR_W'(FRAME_BASE + IX_RX_FRM);
  localparam logic [ADDR_W-1:0] A_OVER = ADDR_W'(FRAME_BASE + IX_RX_OVER);
  localparam logic [ADDR_W-1:0] A_GAP0 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_GAP1 = ADDR_W'(FRAME_BASE);
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(FRAME_BASE + NUM_CNT);

  logic unmapped;
  assign unmapped = (rdAddr >= A_GAP0 && rdAddr < A_GAP1) || (rdAddr >= A_TOP);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && unmapped) |=> (rdData == '0));

  // R7 and R8: second back-to-back read sees only the event of the first read cycle
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == A_RXFR && $past(rdEn && rdAddr == A_RXFR && !clearStats))
      |=> (rdData == CNT_W'($past(rxValid, 2))));

  a_r11_fifo_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == A_OVER) |=> (rdData[CNT_W-1] == $past(rxFifoNotEmpty)));

  a_r12_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == A_RXFR && $past(clearStats)) |=> (rdData == '0));

endmodule

bind rmon_stats_bank rmon_stats_sva #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rstN(rstN), .clearStats(clearStats), .rxValid(rxValid),
  .rxFifoNotEmpty(rxFifoNotEmpty), .rdEn(rdEn), .rdAddr(rdAddr),
  .rdData(rdData), .rdValid(rdValid)
);

// File: tb/test_rmon_stats_bank.sv
module test_rmon_stats_bank;

  localparam int CNT_W  = 8;
  localparam int BYTE_W = 12;
  localparam int LEN_W  = 12;
  localparam int ADDR_W = 6;

  // receive flag bits for the bench tasks
  localparam int F_FCS = 0, F_MC = 1, F_BC = 2, F_PS = 3;
  localparam int F_SHORT = 4, F_LONG = 5, F_JAB = 6, F_SYM = 7;
  // transmit flag bits
  localparam int T_ERR = 0, T_MC = 1, T_BC = 2, T_PS = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clearStats = 1'b0;
  logic              rxValid = 1'b0;
  logic [LEN_W-1:0]  rxLen = '0;
  logic              rxFcsBad = 1'b0, rxMcast = 1'b0, rxBcast = 1'b0, rxPause = 1'b0;
  logic              rxShort = 1'b0, rxLong = 1'b0, rxJabber = 1'b0, rxSymErr = 1'b0;
  logic              rxFifoNotEmpty = 1'b0;
  logic              txValid = 1'b0;
  logic [LEN_W-1:0]  txLen = '0;
  logic              txErr = 1'b0, txMcast = 1'b0, txBcast = 1'b0, txPause = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [CNT_W-1:0]  rdData;
  logic              rdValid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rmon_stats_bank #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W))
  i_rmon_stats_bank (
    .clk(clk), .rstN(rstN), .clearStats(clearStats),
    .rxValid(rxValid), .rxLen(rxLen), .rxFcsBad(rxFcsBad), .rxMcast(rxMcast),
    .rxBcast(rxBcast), .rxPause(rxPause), .rxShort(rxShort), .rxLong(rxLong),
    .rxJabber(rxJabber), .rxSymErr(rxSymErr), .rxFifoNotEmpty(rxFifoNotEmpty),
    .txValid(txValid), .txLen(txLen), .txErr(txErr), .txMcast(txMcast),
    .txBcast(txBcast), .txPause(txPause),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setRx(input int len, input logic [7:0] f);
    rxValid  = 1'b1;
    rxLen    = LEN_W'(len);
    rxFcsBad = f[F_FCS];  rxMcast = f[F_MC];   rxBcast  = f[F_BC];  rxPause  = f[F_PS];
    rxShort  = f[F_SHORT]; rxLong = f[F_LONG]; rxJabber = f[F_JAB]; rxSymErr = f[F_SYM];
  endtask

  task automatic sendRx(input int len, input logic [7:0] f);
    @(negedge clk);
    setRx(len, f);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic sendTx(input int len, input logic [3:0] f);
    @(negedge clk);
    txValid = 1'b1; txLen = LEN_W'(len);
    txErr = f[T_ERR]; txMcast = f[T_MC]; txBcast = f[T_BC]; txPause = f[T_PS];
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic readReg(input int addr, output int data);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = ADDR_W'(addr);
    @(negedge clk);
    rdEn = 1'b0;
    data = int'(rdData);
  endtask

  task automatic rdChk(input string req, input string what, input int addr, input int exp);
    int v;
    readReg(addr, v);
    chk(req, what, v, exp);
  endtask

  task automatic clrAll();
    @(negedge clk);
    clearStats = 1'b1;
    @(negedge clk);
    clearStats = 1'b0;
  endtask

  task automatic testReset();
    chk("R13", "rdValid in reset", int'(rdValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    rdChk("R13", "rx frames after reset", 8, 0);
    rdChk("R13", "rx bytes low after reset", 0, 0);
    rdChk("R13", "tx bin6 after reset", 35, 0);
  endtask

  task automatic testReadTiming();
    @(negedge clk);
    rdEn = 1'b1; rdAddr = ADDR_W'(8);
    @(negedge clk);
    rdEn = 1'b0;
    chk("R1", "rdValid after request", int'(rdValid), 1);
    @(negedge clk);
    chk("R1", "rdValid one cycle only", int'(rdValid), 0);
  endtask

  task automatic testClear();
    sendRx(100, 8'h00);
    sendTx(100, 4'h0);
    @(negedge clk);
    clearStats = 1'b1;
    setRx(70, 8'h00);
    @(negedge clk);
    clearStats = 1'b0; rxValid = 1'b0;
    rdChk("R12", "rx frames after clear with event", 8, 0);
    rdChk("R12", "tx frames after clear", 24, 0);
    rdChk("R12", "rx bytes low after clear", 0, 0);
    rdChk("R12", "rx bin1 after clear", 18, 0);
  endtask

  task automatic testRx();
    clrAll();
    sendRx(64, 8'(1 << F_MC));
    sendRx(100, 8'((1 << F_BC) | (1 << F_FCS)));
    sendRx(1519, 8'((1 << F_PS) | (1 << F_JAB) | (1 << F_LONG) | (1 << F_SHORT) | (1 << F_SYM)));
    rdChk("R2", "rx frames", 8, 3);
    rdChk("R2", "rx multicast", 9, 1);
    rdChk("R2", "rx broadcast", 10, 1);
    rdChk("R2", "rx pause", 11, 1);
    rdChk("R3", "rx fcs errors", 12, 1);
    rdChk("R3", "rx jabber", 13, 1);
    rdChk("R3", "rx short", 14, 1);
    rdChk("R3", "rx symbol errors", 15, 1);
    rdChk("R3", "rx oversize", 16, 1);
    rdChk("R5", "rx bin0 (64)", 17, 1);
    rdChk("R5", "rx bin1 (100)", 18, 1);
    rdChk("R5", "rx bin2 empty", 19, 0);
    rdChk("R5", "rx bin6 (1519)", 23, 1);
    rdChk("R6", "rx bytes low word", 0, 1683 % 256);
    rdChk("R6", "rx bytes high word", 1, 1683 / 256);
    rdChk("R6", "tx frames untouched by rx", 24, 0);
    // R7: second reads return zero
    rdChk("R7", "rx frames reread", 8, 0);
    rdChk("R7", "rx bytes low reread", 0, 0);
  endtask

  task automatic testTx();
    clrAll();
    sendTx(127, 4'(1 << T_MC));
    sendTx(128, 4'(1 << T_BC));
    sendTx(255, 4'(1 << T_PS));
    sendTx(256, 4'(1 << T_ERR));
    sendTx(511, 4'h0);
    sendTx(512, 4'h0);
    sendTx(1023, 4'h0);
    sendTx(1024, 4'h0);
    sendTx(1518, 4'h0);
    rdChk("R4", "tx frames", 24, 9);
    rdChk("R4", "tx multicast", 25, 1);
    rdChk("R4", "tx broadcast", 26, 1);
    rdChk("R4", "tx pause", 27, 1);
    rdChk("R4", "tx errors", 28, 1);
    rdChk("R5", "tx bin0", 29, 0);
    rdChk("R5", "tx bin1 (127)", 30, 1);
    rdChk("R5", "tx bin2 (128,255)", 31, 2);
    rdChk("R5", "tx bin3 (256,511)", 32, 2);
    rdChk("R5", "tx bin4 (512,1023)", 33, 2);
    rdChk("R5", "tx bin5 (1024,1518)", 34, 2);
    rdChk("R5", "tx bin6", 35, 0);
    // 5354 bytes exceed 4095: byte counter saturates (R10)
    rdChk("R10", "tx bytes low saturated", 2, 255);
    rdChk("R10", "tx bytes high saturated", 3, 15);
    rdChk("R6", "rx frames untouched by tx", 8, 0);
    clrAll();
    sendRx(65, 8'h00);
    sendRx(1518, 8'h00);
    rdChk("R5", "rx bin0 boundary 65", 17, 0);
    rdChk("R5", "rx bin1 boundary 65", 18, 1);
    rdChk("R5", "rx bin5 boundary 1518", 22, 1);
    rdChk("R5", "rx bin6 boundary 1518", 23, 0);
  endtask

  task automatic testConcurrent();
    int v;
    clrAll();
    @(negedge clk);
    rdEn = 1'b1; rdAddr = ADDR_W'(8);
    setRx(200, 8'h00);
    @(negedge clk);
    rdEn = 1'b0; rxValid = 1'b0;
    chk("R8", "frame read with event returns old", int'(rdData), 0);
    rdChk("R8", "frame counter left at 1", 8, 1);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = ADDR_W'(0);
    setRx(50, 8'h00);
    @(negedge clk);
    rdEn = 1'b0; rxValid = 1'b0;
    chk("R8", "byte read with event returns old", int'(rdData), 200);
    readReg(1, v);
    chk("R8", "byte high after concurrent read", v, 0);
    rdChk("R8", "byte counter left at frame length", 0, 50);
  endtask

  task automatic testAtomic();
    clrAll();
    sendRx(300, 8'h00);
    rdChk("R9", "low word", 0, 300 % 256);
    sendRx(1000, 8'h00);
    rdChk("R9", "high word from capture", 1, 300 / 256);
    rdChk("R9", "next low word", 0, 1000 % 256);
    rdChk("R9", "next high word", 1, 1000 / 256);
  endtask

  task automatic testSaturate();
    clrAll();
    @(negedge clk);
    setRx(64, 8'(1 << F_LONG));
    repeat (260) @(negedge clk);
    rxValid = 1'b0;
    rdChk("R10", "rx frames saturated", 8, 255);
    rdChk("R11", "oversize saturated at 7 bits", 16, 127);
    rdChk("R10", "rx bin0 saturated", 17, 255);
    sendRx(64, 8'(1 << F_LONG));
    sendRx(64, 8'(1 << F_LONG));
    sendRx(64, 8'(1 << F_LONG));
    rxFifoNotEmpty = 1'b1;
    rdChk("R11", "oversize with fifo flag", 16, 128 + 3);
    rxFifoNotEmpty = 1'b0;
    rdChk("R11", "oversize flag clear", 16, 0);
  endtask

  task automatic testUnmapped();
    clrAll();
    sendRx(64, 8'h00);
    rdChk("R6", "address 5 reads zero", 5, 0);
    rdChk("R6", "address 63 reads zero", 63, 0);
    rdChk("R6", "counter kept after unmapped reads", 8, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testReadTiming();
    testClear();
    testRx();
    testTx();
    testConcurrent();
    testAtomic();
    testSaturate();
    testUnmapped();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule